// File: doc/BRIEF.md
# Streaming Bit-Field Insert/Extract Engine

This block moves a bit field of 1 to 16 bits between a 16-bit accumulator and a byte-wide synchronous memory. The field begins at a byte address plus a bit offset of 0 to 15 and may cross several byte boundaries. An insert copies the low bits of the accumulator into the field. An extract copies the field into the low bits of the accumulator. The engine walks the touched bytes one at a time. For an insert, it reads and rewrites each byte so that the bits around the field keep their values.

When an operation ends, the engine presents the accumulator result together with an address and bit offset that point just past the field. A caller can feed these back as the next command, which packs or unpacks a stream of adjacent fields of mixed sizes. Bits are numbered LSB-first inside each byte, and bytes are little-endian.

The control is a five-state machine:
- S_IDLE waits for start.
- S_RD issues a byte read.
- S_CAP captures the returned byte.
- S_WR writes the merged byte back (insert only).
- S_FIN presents the results and pulses done.

The transitions are:
- S_IDLE to S_RD when start is seen.
- S_RD to S_CAP always.
- S_CAP to S_WR for an insert.
- S_CAP to S_RD (extract, more bytes remain).
- S_CAP to S_FIN (extract, last byte).
- S_WR to S_RD (more bytes remain).
- S_WR to S_FIN (last byte).
- S_FIN to S_RD when start is present (back-to-back command).
- S_FIN to S_IDLE otherwise.

Top module: `bfe_engine`

## Requirements
- R1: After reset, busy and done are 0, and acc_out, addr_out and bit_off_out are all 0.
- R2: For an extract (op_insert=0), acc_out bit k equals memory bit (addr_in*8 + bit_off_in + k) for k from 0 to len_code_in. Bit b of byte A is memory bit A*8+b. All acc_out bits above the field are 0, and no memory write occurs.
- R3: For an insert (op_insert=1), the low len_code_in+1 bits of acc_in replace the memory bits starting at memory bit addr_in*8 + bit_off_in. Every other memory bit keeps its value, and acc_out returns acc_in.
- R4: len_code_in values 0 to 15 select a field of 1 to 16 bits.
- R5: A field may touch up to four consecutive bytes starting at addr_in. The engine reads bytes addr_in to addr_in+((bit_off_in+len_code_in)>>3), one per access in rising address order.
- R6: Let s = bit_off_in + len_code_in + 1. At done, bit_off_out equals s mod 16, and addr_out equals addr_in+2 when s is 16 or more and addr_in otherwise.
- R7: busy is 1 from the cycle after start is accepted until done. done is a one-cycle pulse with busy at 0. The number of clock edges from acceptance to done is 2 per touched byte for an extract and 3 per touched byte for an insert.
- R8: start and the command inputs are ignored while busy is 1.
- R9: mem_rd and mem_wr are never 1 together. Each insert write goes to the address read two cycles earlier.
- R10: start present in the done cycle is accepted at once, and the next operation starts without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, accepted when busy is 0 |
| op_insert | input | 1 | 1 = insert, 0 = extract |
| addr_in | input | AW | Base byte address of the field |
| bit_off_in | input | 4 | Bit offset from the base address |
| len_code_in | input | 4 | Field length minus one |
| acc_in | input | 16 | Accumulator value (insert source) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 16 | Extracted field, or acc_in for an insert |
| addr_out | output | AW | Advanced byte address |
| bit_off_out | output | 4 | Advanced bit offset |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |

## Verification
Two functions can coincide in one cycle: the done pulse that closes one operation, and the acceptance of the next command. The bench provokes this by raising start on the very negative edge at which it sees done. It then checks that the second result, its memory effect and its latency match the reference as if the operation had been launched from idle.

The bench also raises start with random command fields during every busy cycle of some operations. It judges that these were ignored by comparing the final outputs and the whole memory against the model.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_CAP,
        S_WR,
        S_FIN
    } bfe_state_e;
endpackage

// File: rtl/bfe_geom.sv
// Field geometry: masks placed in the byte window, last byte index, next position.
module bfe_geom #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [AW-1:0]              addr,
    input  logic [$clog2(DW)-1:0]      off,
    input  logic [$clog2(DW)-1:0]      len,
    input  logic [DW-1:0]              acc,
    output logic [2*DW-1:0]            low_mask,
    output logic [2*DW-1:0]            win_mask,
    output logic [2*DW-1:0]            win_fld,
    output logic [$clog2(DW/4)-1:0]    last_idx,
    output logic [$clog2(DW)-1:0]      nxt_off,
    output logic [AW-1:0]              nxt_addr
);
    localparam int OW   = $clog2(DW);
    localparam int WW   = 2 * DW;
    localparam int NBW  = $clog2(DW/4);
    localparam int STEP = DW / 8;

    logic [OW:0] end_pos;
    logic [OW:0] sum;

    always_comb begin
        low_mask = (WW'(1) << (32'(len) + 32'd1)) - WW'(1);
        win_mask = low_mask << off;
        win_fld  = (WW'(acc) & low_mask) << off;
        end_pos  = {1'b0, off} + {1'b0, len};
        last_idx = NBW'(end_pos >> 3);
        sum      = end_pos + (OW+1)'(1);
        nxt_off  = sum[OW-1:0];
        nxt_addr = addr + (sum[OW] ? AW'(STEP) : AW'(0));
    end
endmodule

// File: rtl/bfe_ctrl.sv
// Sequencer: walks the touched bytes with read / capture / write steps.
module bfe_ctrl
    import bfe_pkg::*;
#(
    parameter int NBW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           is_ins,
    input  logic [NBW-1:0] last_idx,
    output logic [NBW-1:0] idx,
    output logic           accept,
    output logic           rd,
    output logic           wr,
    output logic           cap,
    output logic           fin_ld,
    output logic           busy,
    output logic           done
);
    bfe_state_e     state, nxt;
    logic [NBW-1:0] idx_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            idx   <= idx_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        idx_nxt = idx;
        accept  = 1'b0;
        rd      = 1'b0;
        wr      = 1'b0;
        cap     = 1'b0;
        fin_ld  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    accept  = 1'b1;
                    idx_nxt = '0;
                    nxt     = S_RD;
                end
            end
            S_RD: begin
                rd  = 1'b1;
                nxt = S_CAP;
            end
            S_CAP: begin
                cap = 1'b1;
                if (is_ins) begin
                    nxt = S_WR;
                end else if (idx == last_idx) begin
                    fin_ld = 1'b1;
                    nxt    = S_FIN;
                end else begin
                    idx_nxt = idx + NBW'(1);
                    nxt     = S_RD;
                end
            end
            S_WR: begin
                wr = 1'b1;
                if (idx == last_idx) begin
                    fin_ld = 1'b1;
                    nxt    = S_FIN;
                end else begin
                    idx_nxt = idx + NBW'(1);
                    nxt     = S_RD;
                end
            end
            S_FIN: begin
                busy = 1'b0;
                done = 1'b1;
                if (start) begin
                    accept  = 1'b1;
                    idx_nxt = '0;
                    nxt     = S_RD;
                end else begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/bfe_engine.sv
module bfe_engine #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  op_insert,
    input  logic [AW-1:0]         addr_in,
    input  logic [$clog2(DW)-1:0] bit_off_in,
    input  logic [$clog2(DW)-1:0] len_code_in,
    input  logic [DW-1:0]         acc_in,
    output logic                  busy,
    output logic                  done,
    output logic [DW-1:0]         acc_out,
    output logic [AW-1:0]         addr_out,
    output logic [$clog2(DW)-1:0] bit_off_out,
    output logic [AW-1:0]         mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [7:0]            mem_wdata,
    input  logic [7:0]            mem_rdata
);
    localparam int OW  = $clog2(DW);
    localparam int WW  = 2 * DW;
    localparam int NB  = WW / 8;
    localparam int NBW = $clog2(NB);

    logic           r_ins;
    logic [AW-1:0]  r_addr;
    logic [OW-1:0]  r_off;
    logic [OW-1:0]  r_len;
    logic [DW-1:0]  r_acc;
    logic [WW-1:0]  win;
    logic [WW-1:0]  win_nx;

    logic [NBW-1:0] idx;
    logic [NBW-1:0] last_idx;
    logic           accept, cap, fin_ld;
    logic [WW-1:0]  low_mask, win_mask, win_fld;
    logic [OW-1:0]  nxt_off;
    logic [AW-1:0]  nxt_addr;
    logic [7:0]     merged [NB];

    bfe_geom #(.AW(AW), .DW(DW)) u_geom (
        .addr     (r_addr),
        .off      (r_off),
        .len      (r_len),
        .acc      (r_acc),
        .low_mask (low_mask),
        .win_mask (win_mask),
        .win_fld  (win_fld),
        .last_idx (last_idx),
        .nxt_off  (nxt_off),
        .nxt_addr (nxt_addr)
    );

    bfe_ctrl #(.NBW(NBW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_ins   (r_ins),
        .last_idx (last_idx),
        .idx      (idx),
        .accept   (accept),
        .rd       (mem_rd),
        .wr       (mem_wr),
        .cap      (cap),
        .fin_ld   (fin_ld),
        .busy     (busy),
        .done     (done)
    );

    // Per-byte window update and read-modify-write merge
    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign win_nx[g*8 +: 8] = (cap && idx == NBW'(g)) ? mem_rdata : win[g*8 +: 8];
        assign merged[g] = (win[g*8 +: 8] & ~win_mask[g*8 +: 8]) | win_fld[g*8 +: 8];
    end

    assign mem_addr  = r_addr + AW'(idx);
    assign mem_wdata = merged[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_ins       <= 1'b0;
            r_addr      <= '0;
            r_off       <= '0;
            r_len       <= '0;
            r_acc       <= '0;
            win         <= '0;
            acc_out     <= '0;
            addr_out    <= '0;
            bit_off_out <= '0;
        end else begin
            if (accept) begin
                r_ins  <= op_insert;
                r_addr <= addr_in;
                r_off  <= bit_off_in;
                r_len  <= len_code_in;
                r_acc  <= acc_in;
                win    <= '0;
            end else begin
                win <= win_nx;
            end
            if (fin_ld) begin
                acc_out     <= r_ins ? r_acc : DW'((win_nx >> r_off) & low_mask);
                addr_out    <= nxt_addr;
                bit_off_out <= nxt_off;
            end
        end
    end
endmodule

// File: rtl/bfe_engine_chk.sv
module bfe_engine_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  op_insert,
    input logic [AW-1:0]         addr_in,
    input logic [$clog2(DW)-1:0] bit_off_in,
    input logic [$clog2(DW)-1:0] len_code_in,
    input logic                  busy,
    input logic                  done,
    input logic [DW-1:0]         acc_out,
    input logic [AW-1:0]         addr_out,
    input logic [$clog2(DW)-1:0] bit_off_out,
    input logic [AW-1:0]         mem_addr,
    input logic                  mem_rd,
    input logic                  mem_wr
);
    localparam int OW = $clog2(DW);

    logic          c_ins;
    logic [AW-1:0] c_addr;
    logic [OW-1:0] c_off;
    logic [OW-1:0] c_len;
    logic [OW:0]   c_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_ins  <= 1'b0;
            c_addr <= '0;
            c_off  <= '0;
            c_len  <= '0;
        end else if (start && !busy) begin
            c_ins  <= op_insert;
            c_addr <= addr_in;
            c_off  <= bit_off_in;
            c_len  <= len_code_in;
        end
    end

    assign c_sum = {1'b0, c_off} + {1'b0, c_len} + (OW+1)'(1);

    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    p_no_write_extract_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !c_ins) |-> !mem_wr);

    p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !c_ins) |-> ((32'(acc_out) >> (32'(c_len) + 32'd1)) == 32'd0));

    p_next_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bit_off_out == c_sum[OW-1:0]));

    p_next_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (addr_out == c_addr + (c_sum[OW] ? AW'(DW/8) : AW'(0))));
endmodule

bind bfe_engine bfe_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_insert   (op_insert),
    .addr_in     (addr_in),
    .bit_off_in  (bit_off_in),
    .len_code_in (len_code_in),
    .busy        (busy),
    .done        (done),
    .acc_out     (acc_out),
    .addr_out    (addr_out),
    .bit_off_out (bit_off_out),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr)
);

// File: tb/bfe_engine_bench.sv
module bfe_engine_bench;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_insert = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [3:0]    bit_off_in = '0;
    logic [3:0]    len_code_in = '0;
    logic [DW-1:0] acc_in = '0;
    logic          busy, done, mem_rd, mem_wr;
    logic [DW-1:0] acc_out;
    logic [AW-1:0] addr_out, mem_addr;
    logic [3:0]    bit_off_out;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;

    logic [7:0] mem    [256];
    logic [7:0] shadow [256];

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    bfe_engine #(.AW(AW), .DW(DW)) u_bfe_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_insert(op_insert),
        .addr_in(addr_in), .bit_off_in(bit_off_in), .len_code_in(len_code_in),
        .acc_in(acc_in), .busy(busy), .done(done), .acc_out(acc_out),
        .addr_out(addr_out), .bit_off_out(bit_off_out), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Synchronous byte memory: read data appears the cycle after mem_rd
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_extract(input int a, input int off, input int len);
        logic [15:0] r = '0;
        for (int k = 0; k <= len; k++) begin
            int p = a * 8 + off + k;
            r[k] = shadow[p >> 3][p & 7];
        end
        return r;
    endfunction

    task automatic ref_insert(input int a, input int off, input int len, input logic [15:0] v);
        for (int k = 0; k <= len; k++) begin
            int p = a * 8 + off + k;
            shadow[p >> 3][p & 7] = v[k];
        end
    endtask

    // Entered and left at a negative edge. chain: leave start to the next call.
    task automatic op(input bit ins, input int a, input int off, input int len,
                      input logic [15:0] acc, input bit noise, input bit chain);
        logic [15:0] exp_acc;
        int s, exp_off, exp_addr, nbytes, exp_cyc, cnt, mism;
        bit busy_ok;
        s        = off + len + 1;
        exp_off  = s % 16;
        exp_addr = (s >= 16) ? a + 2 : a;
        nbytes   = ((off + len) >> 3) + 1;
        exp_cyc  = nbytes * (ins ? 3 : 2);
        if (ins) begin
            exp_acc = acc;
            ref_insert(a, off, len, acc);
        end else begin
            exp_acc = ref_extract(a, off, len);
        end
        start = 1'b1; op_insert = ins; addr_in = AW'(a);
        bit_off_in = 4'(off); len_code_in = 4'(len); acc_in = acc;
        @(posedge clk); @(negedge clk);
        cnt = 0;
        busy_ok = 1'b1;
        while (!done && cnt < 200) begin
            if (!busy) busy_ok = 1'b0;
            start = noise ? 1'($urandom) : 1'b0;
            op_insert = 1'($urandom); addr_in = AW'($urandom);
            bit_off_in = 4'($urandom); len_code_in = 4'($urandom); acc_in = 16'($urandom);
            @(posedge clk); @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(busy_ok, "R7 busy held", 32'(busy_ok), 32'd1);
        chk(cnt == exp_cyc, "R7/R5 latency", 32'(cnt), 32'(exp_cyc));
        chk(done && !busy, "R7 done without busy", {30'd0, done, busy}, 32'h2);
        chk(acc_out == exp_acc, ins ? "R3 acc_out" : "R2/R4 extract",
            32'(acc_out), 32'(exp_acc));
        chk(bit_off_out == 4'(exp_off), "R6 offset", 32'(bit_off_out), 32'(exp_off));
        chk(addr_out == AW'(exp_addr), "R6 address", 32'(addr_out), 32'(exp_addr));
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) mism++;
        chk(mism == 0, "R3/R2/R8 memory image", 32'(mism), 32'd0);
        if (!chain) begin
            @(posedge clk); @(negedge clk);
            chk(!done && !busy, "R7 single done pulse", {30'd0, done, busy}, 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 flags", {30'd0, busy, done}, 32'd0);
        chk(acc_out == 0 && addr_out == 0 && bit_off_out == 0, "R1 outputs",
            32'(acc_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        op(1'b0, 10, 0, 0, 16'h0, 1'b0, 1'b0);          // R4 single bit
        op(1'b1, 20, 0, 0, 16'hFFFF, 1'b0, 1'b0);       // R4 single bit insert
        op(1'b1, 30, 7, 1, 16'h0002, 1'b0, 1'b0);       // straddle 1 boundary
        op(1'b1, 40, 15, 15, 16'hA5C3, 1'b0, 1'b0);     // R5 four bytes
        op(1'b0, 40, 15, 15, 16'h0, 1'b0, 1'b0);        // R5 read back
        op(1'b0, 50, 8, 7, 16'h0, 1'b0, 1'b0);          // R6 sum exactly 16
        op(1'b0, 60, 3, 11, 16'h0, 1'b1, 1'b0);         // R8 noise while busy
        op(1'b1, 70, 5, 9, 16'h1234, 1'b1, 1'b0);       // R8 noise on insert
        // R10: back-to-back stream from the done cycle
        op(1'b1, 80, 6, 12, 16'h7E5B, 1'b0, 1'b1);
        op(1'b1, 82, 3, 4, 16'h001F, 1'b0, 1'b1);
        op(1'b0, 80, 6, 12, 16'h0, 1'b0, 1'b1);
        op(1'b0, 82, 3, 4, 16'h0, 1'b0, 1'b0);
        // Random mix
        for (int n = 0; n < 80; n++) begin
            op(1'($urandom), 1 + ($urandom % 200), $urandom % 16, $urandom % 16,
               16'($urandom), 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule